// File: doc/BRIEF.md
# Banked Stack Pointer Control Unit

This unit keeps the two stack pointers of a small processor core: a main pointer and a process pointer. It also keeps the two-bit CONTROL value and the interrupt-mask flag. One of the two pointers is active and goes to the core on `active_sp`. The other is held in a banked register. The only record of which pointer is active is bit 1 of CONTROL (the stack-select bit). Every pointer access routes through that bit, so a CONTROL read always names the pointer that is actually in use.

The core reaches the unit through special-register numbers. A read is combinational from the present state. A write, an exception entry pulse or an exception return pulse takes effect on the next clock edge. On exception entry the unit supplies the link-register return code, computed from the state before the edge. The entry then switches to the main stack. On exception return the stack-select bit is restored from bit 2 of the return code the core supplies. Each change of stack select swaps the active and banked registers.

The access port is a plain single-cycle register port. It has no valid/ready pair because it can never stall: every access completes in the cycle it is presented.

Top module: `sp_bank_unit`

## Requirements
- R1: Register number 20 is CONTROL. A write stores data bits [1:0], where bit 0 is the unprivileged-thread flag and bit 1 is stack select, and drops all other bits. A read returns the stored two bits with all upper bits zero.
- R2: When the stack-select bit changes value, the active pointer and the banked pointer exchange contents on that edge.
- R3: A CONTROL write whose bit 1 equals the current stack select leaves both pointers unchanged.
- R4: Register number 8 is the main pointer. A read returns the banked copy when stack select is 1 and the active pointer when it is 0. A write goes to the same place.
- R5: Register number 9 is the process pointer. A read returns the active pointer when stack select is 1 and the banked copy when it is 0. A write goes to the same place.
- R6: Register number 16 is the interrupt mask. A write loads data bit 0. A read returns that flag in bit 0 with all other bits zero.
- R7: While `exc_entry` is high, `lr_code` equals 0xFFFFFFF1, with bit 2 set if stack select is 1 and bit 3 set if `exc_active` is low.
- R8: Exception entry clears stack select at the next edge, swapping the pointers if stack select was 1. The unprivileged flag is kept.
- R9: Exception return sets stack select to bit 2 of `exc_ret_code` at the next edge, swapping the pointers if the value changes. The unprivileged flag is kept.
- R10: After reset, CONTROL and the interrupt mask are 0, the main pointer is active, and both pointers hold `RESET_SP`.
- R11: Register numbers other than 8, 9, 16 and 20 read as zero, and writes to them change no state.
- R12: In a cycle with an exception event, any register write is dropped. If entry and return arrive together, entry wins.
- R13: `active_sp` always equals the pointer selected by stack select, which is the process pointer when CONTROL bit 1 is 1 and the main pointer otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Special-register write strobe |
| reg_addr | input | 8 | Special-register number for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| exc_entry | input | 1 | Exception entry pulse |
| exc_active | input | 1 | An exception is already being handled |
| exc_return | input | 1 | Exception return pulse |
| exc_ret_code | input | 32 | Return code presented with `exc_return` |
| lr_code | output | 32 | Link-register return code for an entry this cycle |
| active_sp | output | 32 | Stack pointer currently in use |
| ctrl_out | output | 2 | Current CONTROL value |
| primask_out | output | 1 | Current interrupt-mask flag |

## Verification
A register write and an exception event can arrive in the same cycle. The most telling case is a CONTROL or pointer write together with an entry or return pulse, because both would change stack select or a pointer. The bench raises both at once, in random cycles and in directed cases. It expects the write to vanish: its model applies only the event, then compares the pointer reads and `active_sp` on the following cycle. Entry and return arriving together is judged the same way, and only the entry effect is expected.

// File: rtl/sp_bank_pkg.sv
package sp_bank_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned CTRL_W    = 2;
  localparam int unsigned SEL_BIT   = 1;
  localparam int unsigned NPRIV_BIT = 0;

  localparam logic [ADDR_W-1:0] RN_MAIN = 8'd8;
  localparam logic [ADDR_W-1:0] RN_PROC = 8'd9;
  localparam logic [ADDR_W-1:0] RN_MASK = 8'd16;
  localparam logic [ADDR_W-1:0] RN_CTRL = 8'd20;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_ENTRY = 2'd1,
    EV_RET   = 2'd2,
    EV_WRITE = 2'd3
  } ev_kind_e;
endpackage

// File: rtl/sp_bank_ctl.sv
module sp_bank_ctl
  import sp_bank_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                 reg_wr_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  input  logic                 exc_entry,
  input  logic                 exc_return,
  input  logic [DATA_W-1:0]    exc_ret_code,
  input  logic [CTRL_W-1:0]    ctrl_cur,
  output ev_kind_e             ev_kind,
  output logic [CTRL_W-1:0]    ctrl_next,
  output logic                 ctrl_we,
  output logic                 swap,
  output logic                 act_we,
  output logic                 bank_we,
  output logic                 mask_we
);
  logic sel_cur;
  logic sel_next;

  assign sel_cur = ctrl_cur[SEL_BIT];

  always_comb begin
    if (exc_entry)       ev_kind = EV_ENTRY;
    else if (exc_return) ev_kind = EV_RET;
    else if (reg_wr_en)  ev_kind = EV_WRITE;
    else                 ev_kind = EV_NONE;
  end

  always_comb begin
    ctrl_next = ctrl_cur;
    ctrl_we   = 1'b0;
    act_we    = 1'b0;
    bank_we   = 1'b0;
    mask_we   = 1'b0;
    unique case (ev_kind)
      EV_ENTRY: begin
        ctrl_next[SEL_BIT] = 1'b0;
        ctrl_we            = 1'b1;
      end
      EV_RET: begin
        ctrl_next[SEL_BIT] = exc_ret_code[2];
        ctrl_we            = 1'b1;
      end
      EV_WRITE: begin
        unique case (reg_addr)
          RN_CTRL: begin
            ctrl_next = reg_wdata[CTRL_W-1:0];
            ctrl_we   = 1'b1;
          end
          RN_MAIN: begin
            bank_we = sel_cur;
            act_we  = ~sel_cur;
          end
          RN_PROC: begin
            act_we  = sel_cur;
            bank_we = ~sel_cur;
          end
          RN_MASK: mask_we = 1'b1;
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  assign sel_next = ctrl_next[SEL_BIT];
  assign swap     = ctrl_we & (sel_next != sel_cur);
endmodule

// File: rtl/sp_bank_store.sv
module sp_bank_store
  import sp_bank_pkg::*;
#(
  parameter int unsigned       DATA_W   = 32,
  parameter logic [DATA_W-1:0] RESET_SP = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 swap,
  input  logic                 act_we,
  input  logic                 bank_we,
  input  logic                 ctrl_we,
  input  logic [CTRL_W-1:0]    ctrl_next,
  input  logic                 mask_we,
  output logic [DATA_W-1:0]    act_sp,
  output logic [DATA_W-1:0]    bank_sp,
  output logic [CTRL_W-1:0]    ctrl_q,
  output logic                 mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_sp  <= RESET_SP;
      bank_sp <= RESET_SP;
    end else if (swap) begin
      act_sp  <= bank_sp;
      bank_sp <= act_sp;
    end else begin
      if (act_we)  act_sp  <= wdata;
      if (bank_we) bank_sp <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_next;
      if (mask_we) mask_q <= wdata[0];
    end
  end
endmodule

// File: rtl/sp_bank_rdmux.sv
module sp_bank_rdmux
  import sp_bank_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] act_sp,
  input  logic [DATA_W-1:0] bank_sp,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic              mask_q,
  input  logic              exc_active,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] lr_code
);
  localparam int unsigned       PAD_W   = DATA_W - CTRL_W;
  localparam logic [DATA_W-1:0] LR_BASE = {{(DATA_W-4){1'b1}}, 4'b0001};

  logic sel;
  assign sel = ctrl_q[SEL_BIT];

  always_comb begin
    unique case (reg_addr)
      RN_MAIN: reg_rdata = sel ? bank_sp : act_sp;
      RN_PROC: reg_rdata = sel ? act_sp : bank_sp;
      RN_MASK: reg_rdata = {{(DATA_W-1){1'b0}}, mask_q};
      RN_CTRL: reg_rdata = {{PAD_W{1'b0}}, ctrl_q};
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    lr_code    = LR_BASE;
    lr_code[2] = sel;
    lr_code[3] = ~exc_active;
  end
endmodule

// File: rtl/sp_bank_unit.sv
module sp_bank_unit
  import sp_bank_pkg::*;
#(
  parameter int unsigned       DATA_W   = 32,
  parameter logic [DATA_W-1:0] RESET_SP = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              exc_entry,
  input  logic              exc_active,
  input  logic              exc_return,
  input  logic [DATA_W-1:0] exc_ret_code,
  output logic [DATA_W-1:0] lr_code,
  output logic [DATA_W-1:0] active_sp,
  output logic [1:0]        ctrl_out,
  output logic              primask_out
);
  ev_kind_e              ev_kind;
  logic [CTRL_W-1:0]     ctrl_next;
  logic [CTRL_W-1:0]     ctrl_q;
  logic                  ctrl_we;
  logic                  swap;
  logic                  act_we;
  logic                  bank_we;
  logic                  mask_we;
  logic                  mask_q;
  logic [DATA_W-1:0]     act_sp;
  logic [DATA_W-1:0]     bank_sp;

  sp_bank_ctl #(.DATA_W(DATA_W)) u_ctl (
    .reg_wr_en    (reg_wr_en),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .exc_entry    (exc_entry),
    .exc_return   (exc_return),
    .exc_ret_code (exc_ret_code),
    .ctrl_cur     (ctrl_q),
    .ev_kind      (ev_kind),
    .ctrl_next    (ctrl_next),
    .ctrl_we      (ctrl_we),
    .swap         (swap),
    .act_we       (act_we),
    .bank_we      (bank_we),
    .mask_we      (mask_we)
  );

  sp_bank_store #(.DATA_W(DATA_W), .RESET_SP(RESET_SP)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdata     (reg_wdata),
    .swap      (swap),
    .act_we    (act_we),
    .bank_we   (bank_we),
    .ctrl_we   (ctrl_we),
    .ctrl_next (ctrl_next),
    .mask_we   (mask_we),
    .act_sp    (act_sp),
    .bank_sp   (bank_sp),
    .ctrl_q    (ctrl_q),
    .mask_q    (mask_q)
  );

  sp_bank_rdmux #(.DATA_W(DATA_W)) u_rd (
    .reg_addr   (reg_addr),
    .act_sp     (act_sp),
    .bank_sp    (bank_sp),
    .ctrl_q     (ctrl_q),
    .mask_q     (mask_q),
    .exc_active (exc_active),
    .reg_rdata  (reg_rdata),
    .lr_code    (lr_code)
  );

  assign active_sp   = act_sp;
  assign ctrl_out    = ctrl_q;
  assign primask_out = mask_q;
endmodule

// File: rtl/sp_bank_chk.sv
module sp_bank_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [7:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              exc_entry,
  input logic              exc_active,
  input logic              exc_return,
  input logic [DATA_W-1:0] exc_ret_code,
  input logic [DATA_W-1:0] lr_code,
  input logic [DATA_W-1:0] active_sp,
  input logic [1:0]        ctrl_out,
  input logic [DATA_W-1:0] bank_sp
);
  a_r1_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'd20) |-> (reg_rdata[DATA_W-1:2] == '0));

  a_r2_swap_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_out[1] != $past(ctrl_out[1])) |->
      (active_sp == $past(bank_sp) && bank_sp == $past(active_sp)));

  a_r3_same_sel_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == 8'd20 && !exc_entry && !exc_return &&
     reg_wdata[1] == ctrl_out[1]) |=> ($stable(active_sp) && $stable(bank_sp)));

  a_r7_lr_code: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |-> (lr_code[DATA_W-1:4] == '1 && lr_code[1:0] == 2'b01 &&
                   lr_code[2] == ctrl_out[1] && lr_code[3] == !exc_active));

  a_r8_entry_main: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> (ctrl_out[1] == 1'b0 && ctrl_out[0] == $past(ctrl_out[0])));

  a_r9_return_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_entry) |=> (ctrl_out[1] == $past(exc_ret_code[2])));

  a_r11_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != 8'd8 && reg_addr != 8'd9 && reg_addr != 8'd16 &&
     reg_addr != 8'd20) |-> (reg_rdata == '0));

  a_r12_event_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((exc_entry || exc_return) && reg_wr_en && (reg_addr == 8'd8 || reg_addr == 8'd9) &&
     ctrl_out[1] == (exc_entry ? 1'b0 : exc_ret_code[2])) |=>
      ($stable(active_sp) && $stable(bank_sp)));
endmodule

bind sp_bank_unit sp_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr_en    (reg_wr_en),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .exc_entry    (exc_entry),
  .exc_active   (exc_active),
  .exc_return   (exc_return),
  .exc_ret_code (exc_ret_code),
  .lr_code      (lr_code),
  .active_sp    (active_sp),
  .ctrl_out     (ctrl_out),
  .bank_sp      (bank_sp)
);

// File: tb/sp_bank_unit_test.sv
module sp_bank_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        exc_entry;
  logic        exc_active;
  logic        exc_return;
  logic [31:0] exc_ret_code;
  logic [31:0] lr_code;
  logic [31:0] active_sp;
  logic [1:0]  ctrl_out;
  logic        primask_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] m_main, m_proc;
  logic [1:0]  m_ctrl;
  logic        m_mask;

  always #5 clk = ~clk;

  sp_bank_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exc_entry(exc_entry),
    .exc_active(exc_active), .exc_return(exc_return), .exc_ret_code(exc_ret_code),
    .lr_code(lr_code), .active_sp(active_sp), .ctrl_out(ctrl_out),
    .primask_out(primask_out)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'd8:    return m_main;
      8'd9:    return m_proc;
      8'd16:   return {31'd0, m_mask};
      8'd20:   return {30'd0, m_ctrl};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string read_tag(input logic [7:0] a);
    case (a)
      8'd8:    return "R4";
      8'd9:    return "R5";
      8'd16:   return "R6";
      8'd20:   return "R1";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] exp_lr(input logic sel, input logic act);
    return 32'hFFFF_FFF1 | {28'd0, ~act, sel, 2'b00};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    if (exc_entry) m_ctrl[1] = 1'b0;
    else if (exc_return) m_ctrl[1] = exc_ret_code[2];
    else if (reg_wr_en) begin
      case (reg_addr)
        8'd8:  m_main = reg_wdata;
        8'd9:  m_proc = reg_wdata;
        8'd16: m_mask = reg_wdata[0];
        8'd20: m_ctrl = reg_wdata[1:0];
        default: ;
      endcase
    end
  endtask

  // Drive one cycle (inputs set after negedge), check combinational outputs, then clock.
  task automatic cycle(input logic we, input logic [7:0] a, input logic [31:0] d,
                       input logic en, input logic ea, input logic rt,
                       input logic [31:0] rc, input string tag);
    reg_wr_en = we; reg_addr = a; reg_wdata = d;
    exc_entry = en; exc_active = ea; exc_return = rt; exc_ret_code = rc;
    #2;
    check({read_tag(a), " ", tag}, reg_rdata, exp_read(a));
    check({"R13 ", tag}, active_sp, m_ctrl[1] ? m_proc : m_main);
    if (en) check({"R7 ", tag}, lr_code, exp_lr(m_ctrl[1], ea));
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cycle(1'b0, a, 32'd0, 1'b0, 1'b0, 1'b0, 32'd0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    cycle(1'b1, a, d, 1'b0, 1'b0, 1'b0, 32'd0, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [5];
    int unused_seed;
    addrs = '{8'd8, 8'd9, 8'd16, 8'd20, 8'd3};
    unused_seed = $urandom(32'd1234);
    rst_n = 1'b0; reg_wr_en = 0; reg_addr = 0; reg_wdata = 0;
    exc_entry = 0; exc_active = 0; exc_return = 0; exc_ret_code = 0;
    m_main = 0; m_proc = 0; m_ctrl = 0; m_mask = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    check("R10 ctrl", {30'd0, ctrl_out}, 32'd0);
    check("R10 mask", {31'd0, primask_out}, 32'd0);
    check("R10 sp", active_sp, 32'd0);

    // R4 R5 routing with main stack active
    wr(8'd8, 32'h1000_0000, "R4 write main");
    wr(8'd9, 32'h2000_0000, "R5 write proc");
    rd(8'd8, "R4"); rd(8'd9, "R5");
    // R1 masking; R2 swap on select change
    wr(8'd20, 32'hFFFF_FFFE, "R1 mask upper");
    rd(8'd20, "R1 readback");
    check("R2 active after select", active_sp, 32'h2000_0000);
    // R3 same select rewrite, no exchange
    wr(8'd20, 32'h0000_0002, "R3");
    check("R3 no swap", active_sp, 32'h2000_0000);
    wr(8'd8, 32'h1111_0000, "R4 banked write");
    rd(8'd8, "R4 banked read"); rd(8'd9, "R5 active read");
    // R6 mask
    wr(8'd16, 32'hFFFF_FFFF, "R6 set"); rd(8'd16, "R6 read");
    wr(8'd16, 32'h0000_0002, "R6 clear"); rd(8'd16, "R6 read0");
    // R11 unknown write ignored
    wr(8'd3, 32'hDEAD_BEEF, "R11 write"); rd(8'd3, "R11 read");
    rd(8'd8, "R11 main kept"); rd(8'd9, "R11 proc kept");
    // R7 R8 entry from process stack in thread mode
    cycle(1'b0, 8'd20, 0, 1'b1, 1'b0, 1'b0, 0, "R8 entry");
    check("R8 main active", active_sp, 32'h1111_0000);
    rd(8'd20, "R8 ctrl");
    // R9 return to process stack
    cycle(1'b0, 8'd9, 0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFD, "R9 return");
    check("R9 proc active", active_sp, 32'h2000_0000);
    // R12 write during entry dropped; entry beats return
    cycle(1'b1, 8'd9, 32'h5555_5555, 1'b1, 1'b1, 1'b0, 0, "R12 write+entry");
    rd(8'd9, "R12 proc kept");
    cycle(1'b1, 8'd20, 32'h2, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFD, "R12 entry+return");
    rd(8'd20, "R12 ctrl after");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      logic we, en, rt;
      a  = addrs[$urandom_range(0, 4)];
      we = ($urandom_range(0, 1) == 1);
      en = ($urandom_range(0, 9) == 0);
      rt = ($urandom_range(0, 9) == 0);
      cycle(we, a, $urandom(), en, $urandom_range(0, 1) == 1, rt,
            {$urandom()} | 32'hFFFF_FFF0 | ($urandom_range(0, 1) ? 32'h4 : 32'h0),
            "random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule